// File: doc/BRIEF.md
# Flash Block Lock Guard

This unit sits between the command decoder of a flash memory controller and its erase/program engine. It keeps one lock flag for each of the 71 erase blocks of a top-boot array, plus a single one-way permanent lock. It turns a 21-bit word address into a block number and a block kind (large block, small data block or boot block). From that block number, the block's lock flag and the write-protect pin, it tells the engine whether a modify operation on that address may go ahead.

The command decoder passes the confirm byte of a two-cycle lock command to the unit together with the address. The unit then sets one block flag, clears all block flags, or sets the permanent lock. It raises a one-cycle refusal pulse when the request cannot be carried out. A separate read port returns the stored lock flag of any block and the permanent flag, shaped as 16-bit identifier words.

Top module: `flash_lock_guard`

## Requirements
- R1: An address whose bits [20:15] are not all ones maps to block index equal to bits [20:15] (0 to 62) and to kind 0 (large block).
- R2: An address whose bits [20:15] are all ones maps to index 63 plus bits [14:12]. Indices 63 to 68 give kind 1 (small data block) and indices 69 and 70 give kind 2 (boot block).
- R3: While wp_n is low, any address in a boot block gives chk_allow low, whatever that block's lock flag holds.
- R4: While wp_n is high, a boot block address gives chk_allow high exactly when that block's lock flag is clear.
- R5: For large and small data blocks, chk_allow is high exactly when the block's lock flag is clear, for either level of wp_n.
- R6: A request with confirm byte 01h and no permanent lock sets only the flag of the block holding req_addr. The new flag is visible from the cycle after the request.
- R7: A request with confirm byte D0h and no permanent lock clears every block flag in one cycle.
- R8: A request with confirm byte F1h sets the permanent flag and is never refused. Only reset clears the permanent flag.
- R9: While the permanent flag is set, requests with 01h or D0h change no flag and pulse req_reject high for the one cycle after the request.
- R10: A request with any other confirm byte changes no flag and pulses req_reject for one cycle.
- R11: id_lock_code bit 0 holds the stored flag of the block holding id_addr (1 = locked), and its other bits are zero. id_perm_code bit 0 holds the permanent flag, and its other bits are zero.
- R12: After reset, all block flags and the permanent flag are clear and req_reject is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low protects the boot blocks |
| chk_addr | input | 21 | Word address of a pending modify operation |
| chk_allow | output | 1 | High when the modify operation may proceed |
| chk_index | output | 7 | Block index of chk_addr |
| chk_class | output | 2 | Block kind of chk_addr: 0 large, 1 small data, 2 boot |
| req_valid | input | 1 | Lock configuration request strobe |
| req_cfm | input | 8 | Confirm byte of the lock command |
| req_addr | input | 21 | Address carried with the request |
| req_reject | output | 1 | One-cycle pulse when a request is refused |
| id_addr | input | 21 | Address whose lock flag is reported |
| id_lock_code | output | 16 | Lock identifier word for id_addr's block |
| id_perm_code | output | 16 | Permanent lock identifier word |

## Verification
The bench targets the seam between the last large block and the first small block (indices 62 and 63) and the step from data blocks to boot blocks at index 69. An off-by-one in the address decode would give the wrong lock flag to a whole block. It drives wp_n low against a boot block whose flag is clear, and low against a data block. A design that mixed up the pin's scope would either open a protected boot block or refuse a data block. Once the permanent flag is set, it tries to clear all flags and to set one. A design that checked the permanent flag only on one of these commands would show a changed flag or a missing refusal pulse. It also checks that an unknown confirm byte is refused, that the permanent flag survives a repeat request, and that only reset clears it.

// File: rtl/flp_pkg.sv
// Shared types and command byte values for the flash block lock guard.
package flp_pkg;
    // Block kind reported for every decoded address.
    typedef enum logic [1:0] {
        BLK_MAIN  = 2'd0,
        BLK_PARAM = 2'd1,
        BLK_BOOT  = 2'd2
    } blk_class_t;

    // Confirm bytes of the two-cycle lock configuration commands.
    localparam logic [7:0] CFM_SET_BLOCK = 8'h01;
    localparam logic [7:0] CFM_CLEAR_ALL = 8'hD0;
    localparam logic [7:0] CFM_SET_PERM  = 8'hF1;
endpackage

// File: rtl/flp_addr_map.sv
// Address to block decoder for a top-boot array.
// Assumes the large blocks fill the space below the top large-block-sized
// region. That top region is cut into small blocks, and the highest
// N_BOOT of them are boot blocks. Purely combinational.
module flp_addr_map
    import flp_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int MAIN_SHIFT  = 15,
    parameter int SMALL_SHIFT = 12,
    parameter int N_BOOT      = 2,
    parameter int IDX_W       = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output blk_class_t        cls
);
    localparam int TOP_W   = ADDR_W - MAIN_SHIFT;
    localparam int SUB_W   = MAIN_SHIFT - SMALL_SHIFT;
    localparam int N_MAIN  = (1 << TOP_W) - 1;
    localparam int N_SMALL = 1 << SUB_W;

    logic [TOP_W-1:0] top_f;
    logic [SUB_W-1:0] sub_f;
    logic             unused_low;

    assign top_f      = addr[ADDR_W-1:MAIN_SHIFT];
    assign sub_f      = addr[MAIN_SHIFT-1:SMALL_SHIFT];
    assign unused_low = ^addr[SMALL_SHIFT-1:0];

    // Pick the large-block index, or the small-block index in the top region.
    always_comb begin
        if (top_f == {TOP_W{1'b1}}) begin
            idx = IDX_W'(N_MAIN) + IDX_W'(sub_f);
            cls = (sub_f >= SUB_W'(N_SMALL - N_BOOT)) ? BLK_BOOT : BLK_PARAM;
        end else begin
            idx = IDX_W'(top_f);
            cls = BLK_MAIN;
        end
    end
endmodule

// File: rtl/flp_lock_store.sv
// Lock flag storage and the lock configuration command executor.
// Assumes req_idx is already a valid block index. Each request is acted
// on at the clock edge where req_valid is high. A refusal is shown on
// reject_q for the one following cycle.
module flp_lock_store
    import flp_pkg::*;
#(
    parameter int   N_BLK      = 71,
    parameter int   IDX_W      = 7,
    parameter logic RST_LOCKED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_cfm,
    input  logic [IDX_W-1:0] req_idx,
    output logic [N_BLK-1:0] lock_q,
    output logic             perm_q,
    output logic             reject_q
);
    // Update flags and the refusal pulse from the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= {N_BLK{RST_LOCKED}};
            perm_q   <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= 1'b0;
            if (req_valid) begin
                case (req_cfm)
                    CFM_SET_BLOCK: begin
                        if (perm_q) reject_q <= 1'b1;
                        else        lock_q[req_idx] <= 1'b1;
                    end
                    CFM_CLEAR_ALL: begin
                        if (perm_q) reject_q <= 1'b1;
                        else        lock_q <= '0;
                    end
                    CFM_SET_PERM:  perm_q <= 1'b1;
                    default:       reject_q <= 1'b1;
                endcase
            end
        end
    end

    // R8: the permanent flag never falls outside reset
    a_r8_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        perm_q |=> perm_q);

    // R9: with the permanent flag set, no block flag moves
    a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        perm_q |=> $stable(lock_q));

    // R7: an accepted clear leaves every flag at zero
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cfm == CFM_CLEAR_ALL && !perm_q) |=> (lock_q == '0));

    // R10: unknown confirm bytes are refused and touch nothing
    a_r10_unknown_cfm: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cfm != CFM_SET_BLOCK && req_cfm != CFM_CLEAR_ALL
         && req_cfm != CFM_SET_PERM) |=> (reject_q && $stable(lock_q) && $stable(perm_q)));
endmodule

// File: rtl/flp_gate.sv
// Modify permission decision for one block.
// Assumes lock_bit is the stored flag of the block of kind cls. The
// write-protect pin acts on boot blocks only.
module flp_gate
    import flp_pkg::*;
(
    input  blk_class_t cls,
    input  logic       lock_bit,
    input  logic       wp_n,
    output logic       allow
);
    // Boot blocks need both the pin released and their flag clear.
    always_comb begin
        if (cls == BLK_BOOT) allow = wp_n && !lock_bit;
        else                 allow = !lock_bit;
    end
endmodule

// File: rtl/flash_lock_guard.sv
// Flash block lock guard top level.
// Three address decoders serve the permission check, the configuration
// request and the identifier read. They share one flag store. Inputs are
// synchronous to clk, and check and read results are combinational from
// the stored flags.
module flash_lock_guard
    import flp_pkg::*;
#(
    parameter int   ADDR_W      = 21,
    parameter int   MAIN_SHIFT  = 15,
    parameter int   SMALL_SHIFT = 12,
    parameter int   N_BOOT      = 2,
    parameter logic RST_LOCKED  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_allow,
    output logic [6:0]        chk_index,
    output logic [1:0]        chk_class,
    input  logic              req_valid,
    input  logic [7:0]        req_cfm,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_reject,
    input  logic [ADDR_W-1:0] id_addr,
    output logic [15:0]       id_lock_code,
    output logic [15:0]       id_perm_code
);
    localparam int N_MAIN  = (1 << (ADDR_W - MAIN_SHIFT)) - 1;
    localparam int N_SMALL = 1 << (MAIN_SHIFT - SMALL_SHIFT);
    localparam int N_BLK   = N_MAIN + N_SMALL;
    localparam int IDX_W   = $clog2(N_BLK);

    logic [IDX_W-1:0] chk_idx, req_idx, id_idx;
    blk_class_t       chk_cls, req_cls, id_cls;
    logic [N_BLK-1:0] lock_vec;
    logic             perm_flag;
    logic             unused_cls;

    assign unused_cls = ^{req_cls, id_cls};

    flp_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .SMALL_SHIFT(SMALL_SHIFT),
                   .N_BOOT(N_BOOT), .IDX_W(IDX_W))
        u_map_chk (.addr(chk_addr), .idx(chk_idx), .cls(chk_cls));

    flp_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .SMALL_SHIFT(SMALL_SHIFT),
                   .N_BOOT(N_BOOT), .IDX_W(IDX_W))
        u_map_req (.addr(req_addr), .idx(req_idx), .cls(req_cls));

    flp_addr_map #(.ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .SMALL_SHIFT(SMALL_SHIFT),
                   .N_BOOT(N_BOOT), .IDX_W(IDX_W))
        u_map_id (.addr(id_addr), .idx(id_idx), .cls(id_cls));

    flp_lock_store #(.N_BLK(N_BLK), .IDX_W(IDX_W), .RST_LOCKED(RST_LOCKED))
        u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_valid(req_valid),
            .req_cfm  (req_cfm),
            .req_idx  (req_idx),
            .lock_q   (lock_vec),
            .perm_q   (perm_flag),
            .reject_q (req_reject)
        );

    flp_gate u_gate (
        .cls     (chk_cls),
        .lock_bit(lock_vec[chk_idx]),
        .wp_n    (wp_n),
        .allow   (chk_allow)
    );

    assign chk_index    = 7'(chk_idx);
    assign chk_class    = chk_cls;
    assign id_lock_code = {15'd0, lock_vec[id_idx]};
    assign id_perm_code = {15'd0, perm_flag};

    // R3: the pin alone shuts every boot block
    a_r3_boot_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_class == BLK_BOOT && !wp_n) |-> !chk_allow);

    // R1: large-block kind only below the top region
    a_r1_main_range: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_class == BLK_MAIN) |-> (chk_index < 7'(N_MAIN)));

    // R2: boot blocks are the highest indices
    a_r2_boot_top: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_class == BLK_BOOT) |-> (chk_index >= 7'(N_BLK - N_BOOT)));
endmodule

// File: tb/sim_flash_lock_guard.sv
module sim_flash_lock_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic [20:0] chk_addr = '0;
    logic        chk_allow;
    logic [6:0]  chk_index;
    logic [1:0]  chk_class;
    logic        req_valid = 1'b0;
    logic [7:0]  req_cfm = '0;
    logic [20:0] req_addr = '0;
    logic        req_reject;
    logic [20:0] id_addr = '0;
    logic [15:0] id_lock_code;
    logic [15:0] id_perm_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_lock_guard u0 (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .chk_addr(chk_addr), .chk_allow(chk_allow), .chk_index(chk_index),
        .chk_class(chk_class), .req_valid(req_valid), .req_cfm(req_cfm),
        .req_addr(req_addr), .req_reject(req_reject), .id_addr(id_addr),
        .id_lock_code(id_lock_code), .id_perm_code(id_perm_code)
    );

    // Vector: {req_valid, cfm, req_addr, wp_n, chk/id addr, exp_allow, exp_lock, exp_reject}
    localparam int NV = 17;
    localparam logic [54:0] VEC [NV] = '{
        {1'b0, 8'h00, 21'h000000, 1'b1, 21'h028000, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h01, 21'h02ABCD, 1'b1, 21'h028010, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h00, 21'h000000, 1'b1, 21'h030000, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h01, 21'h1FE123, 1'b1, 21'h1FE000, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'h00, 21'h000000, 1'b1, 21'h1FF000, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h00, 21'h000000, 1'b0, 21'h1FF000, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'h00, 21'h000000, 1'b0, 21'h1FD000, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h01, 21'h1FD7FF, 1'b0, 21'h1FDFFF, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h01, 21'h1F7FFF, 1'b1, 21'h1F0000, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'h55, 21'h000000, 1'b1, 21'h000000, 1'b1, 1'b0, 1'b1},
        {1'b1, 8'hD0, 21'h000000, 1'b1, 21'h028000, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h00, 21'h000000, 1'b1, 21'h1FE000, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h01, 21'h000000, 1'b1, 21'h000000, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'hF1, 21'h000000, 1'b1, 21'h000000, 1'b0, 1'b1, 1'b0},
        {1'b1, 8'hD0, 21'h000000, 1'b1, 21'h000000, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'h01, 21'h1FF000, 1'b1, 21'h1FF000, 1'b1, 1'b0, 1'b1},
        {1'b1, 8'hF1, 21'h000000, 1'b1, 21'h1FF000, 1'b1, 1'b0, 1'b0}
    };
    localparam logic [23:0] VTAG [NV] = '{
        "R5 ", "R6 ", "R6 ", "R4 ", "R4 ", "R3 ", "R5 ", "R5 ", "R6 ",
        "R10", "R7 ", "R7 ", "R6 ", "R8 ", "R9 ", "R9 ", "R8 "
    };

    task automatic check(input logic [23:0] tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk_addr = 21'h1FF000;
        id_addr  = 21'h1FF000;
        #1;
        check("R12", "reject", 32'(req_reject), 32'd0);
        check("R12", "perm", 32'(id_perm_code), 32'd0);
        check("R12", "lock", 32'(id_lock_code), 32'd0);
        check("R12", "allow", 32'(chk_allow), 32'd1);

        // R1 and R2: decode every block
        for (int k = 0; k < 71; k++) begin
            logic [20:0] a;
            logic [1:0]  ec;
            a  = (k < 63) ? 21'(k << 15) : 21'((63 << 15) | ((k - 63) << 12));
            a  = a | 21'h0A5;
            ec = (k < 63) ? 2'd0 : ((k < 69) ? 2'd1 : 2'd2);
            chk_addr = a;
            #1;
            check((k < 63) ? "R1 " : "R2 ", "index", 32'(chk_index), 32'(k));
            check((k < 63) ? "R1 " : "R2 ", "class", 32'(chk_class), 32'(ec));
        end

        // Vector table
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            logic [54:0] e;
            e = VEC[v];
            req_valid = e[54];
            req_cfm   = e[53:46];
            req_addr  = e[45:25];
            wp_n      = e[24];
            chk_addr  = e[23:3];
            id_addr   = e[23:3];
            @(negedge clk);
            req_valid = 1'b0;
            check(VTAG[v], "allow", 32'(chk_allow), 32'(e[2]));
            check(VTAG[v], "lock_code", 32'(id_lock_code), 32'(e[1]));
            check(VTAG[v], "reject", 32'(req_reject), 32'(e[0]));
        end

        // R11: identifier words
        id_addr = 21'h000123;
        #1;
        check("R11", "lock_code", 32'(id_lock_code), 32'h0001);
        check("R11", "perm_code", 32'(id_perm_code), 32'h0001);

        // R9: refusal pulse lasts one cycle only
        @(negedge clk);
        check("R9 ", "reject_idle", 32'(req_reject), 32'd0);

        // R8 and R12: only reset clears the permanent flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 ", "perm_after_reset", 32'(id_perm_code), 32'd0);
        check("R12", "lock_after_reset", 32'(id_lock_code), 32'd0);

        // R7: clear works again once the permanent flag is gone
        req_valid = 1'b1; req_cfm = 8'h01; req_addr = 21'h1FF800;
        @(negedge clk);
        req_cfm = 8'hD0;
        @(negedge clk);
        req_valid = 1'b0;
        id_addr = 21'h1FF800;
        #1;
        check("R7 ", "lock_after_clear", 32'(id_lock_code), 32'd0);
        check("R7 ", "reject", 32'(req_reject), 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule